// File: doc/BRIEF.md
# Timer Register Clock-Domain Bridge

This block sits between a processor clock domain and a faster peripheral clock domain that runs a timer. Each configuration or compare register is written from the processor side. It is kept in a processor-side copy that software reads straight back. The value is then carried to the fast domain with a toggle handshake. In the other direction, the timer's count value and its status flags are sampled together in the fast domain. That pair is carried back to the processor side with a second handshake and exposed as delayed read-back words.

Only one-bit toggles cross the boundary, each through a synchronizer. The multi-bit values sit in registers that stay still while a transfer is in flight. A `sync_mode` input picks the synchronizer depth. When high, both clocks are the same clock and each crossing uses one flop. When low, the clocks are unrelated and each crossing uses two flops. In the unrelated case the fast clock must run at more than twice the processor clock, so that every processor-side value is seen by at least two fast edges. `sync_mode` may change only while `rst_n` is low.

Top module: `trb_bridge`

## Requirements
- R1: After reset, every register reads 0, every fast-side copy on `cfg_fast` is 0, and no `wr_busy` bit is set.
- R2: A write to register index a (0 to N_REGS-1) that is accepted shows its value on `rd_data` with `rd_addr` = a from the first processor edge after the write edge.
- R3: An accepted value reaches its slice `cfg_fast[a*DATA_W +: DATA_W]`. With `sync_mode` high, it appears exactly two clock edges after the write edge, and the slice does not change before that. With `sync_mode` low, it is present when `wr_busy[a]` falls, and other slices are untouched.
- R4: A write to a register whose `wr_busy` bit is set raises `wr_overrun` and not `wr_accept` in that cycle. It is dropped: both the read-back value and the fast-side copy keep the earlier value.
- R5: A write to an idle register raises `wr_accept` combinationally, and its `wr_busy` bit is set from the next edge until the acknowledge returns. With `sync_mode` high, that is exactly three edges. The busy state of one register never blocks writes to another.
- R6: Address decode: `rd_addr` = N_REGS returns the counter mirror, and N_REGS+1 returns the flag mirror in the low FLAG_W bits with zeros above. Any higher address reads 0. A write with `wr_addr` >= N_REGS raises neither `wr_accept` nor `wr_overrun` and changes no register.
- R7: The counter mirror and the flag mirror always come from the same fast-clock sample of `tmr_count` and `tmr_flags`.
- R8: With `sync_mode` high, the status mirrors refresh every four clock edges and show the inputs as they were three edges before the moment they are read. With `sync_mode` low, a free-running counter read through the mirror lags the live count by a bounded amount and is never ahead of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | Processor-domain clock |
| clk_fast | input | 1 | Fast peripheral clock (same clock as clk_cpu when sync_mode is high) |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized in each domain |
| sync_mode | input | 1 | 1: one-flop crossings, shared clock; 0: two-flop crossings |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | $clog2(N_REGS+2) | Register index to write |
| wr_data | input | DATA_W | Write value |
| wr_accept | output | 1 | Write taken and launched across the boundary |
| wr_overrun | output | 1 | Write dropped because that register is still in flight |
| wr_busy | output | N_REGS | Per-register transfer in flight |
| rd_addr | input | $clog2(N_REGS+2) | Read-back index |
| rd_data | output | DATA_W | Read-back value (combinational) |
| cfg_fast | output | N_REGS*DATA_W | Fast-domain register copies, register i at bits i*DATA_W |
| tmr_count | input | DATA_W | Timer count value, fast domain |
| tmr_flags | input | FLAG_W | Timer status flags, fast domain |

## Verification
Several properties are checked on every cycle. Each accepted write shows up in the read-back copy on the next edge, and a dropped write leaves that copy untouched. Acceptance always leads to busy, and accept and overrun never occur together. A fast-side load always takes the processor-side holding value, and the status holding register is frozen while a snapshot is pending. Exact latencies in the shared-clock mode, the refresh period and sample age of the status mirrors, the coherence of the count and flag pair, and the bounded lag with unrelated clocks are shown only by the bench scenarios. In those scenarios a stub counter drives the timer inputs.

// File: rtl/trb_pkg.sv
package trb_pkg;

  // Read-back source selected by the address decoder
  typedef enum logic [1:0] {
    RSEL_REG  = 2'd0,
    RSEL_CNT  = 2'd1,
    RSEL_FLG  = 2'd2,
    RSEL_NONE = 2'd3
  } trb_rsel_e;

endpackage

// File: rtl/trb_rst_sync.sv
module trb_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_n_o = stage_q[1];

endmodule

// File: rtl/trb_tog_sync.sv
module trb_tog_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic one_stage,
  input  logic d,
  output logic q
);

  logic s1_q;
  logic s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  // Shared clock: one flop is enough; unrelated clocks: two flops
  assign q = one_stage ? s1_q : s2_q;

endmodule

// File: rtl/trb_wr_lane.sv
module trb_wr_lane #(
  parameter int DW = 10
) (
  input  logic          clk_cpu,
  input  logic          rst_cpu_n,
  input  logic          clk_fast,
  input  logic          rst_fast_n,
  input  logic          one_stage,
  input  logic          wr_hit,
  input  logic [DW-1:0] wr_data,
  output logic          accept,
  output logic          overrun,
  output logic          busy,
  output logic [DW-1:0] cpu_val,
  output logic [DW-1:0] fast_val
);

  // Processor side: the read-back copy doubles as the holding register
  logic          req_q, req_d;
  logic [DW-1:0] hold_q, hold_d;
  logic          ack_cpu;

  // Fast side
  logic          req_fast;
  logic          seen_q, seen_d;
  logic          load;
  logic [DW-1:0] fast_q, fast_d;

  trb_tog_sync u_req_sync (
    .clk       (clk_fast),
    .rst_n     (rst_fast_n),
    .one_stage (one_stage),
    .d         (req_q),
    .q         (req_fast)
  );

  trb_tog_sync u_ack_sync (
    .clk       (clk_cpu),
    .rst_n     (rst_cpu_n),
    .one_stage (one_stage),
    .d         (seen_q),
    .q         (ack_cpu)
  );

  always_comb begin
    busy    = req_q ^ ack_cpu;
    accept  = wr_hit & ~busy;
    overrun = wr_hit & busy;
    req_d   = req_q ^ accept;
    hold_d  = accept ? wr_data : hold_q;
  end

  always_ff @(posedge clk_cpu or negedge rst_cpu_n) begin
    if (!rst_cpu_n) begin
      req_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      req_q  <= req_d;
      hold_q <= hold_d;
    end
  end

  always_comb begin
    load   = req_fast ^ seen_q;
    seen_d = req_fast;
    fast_d = load ? hold_q : fast_q;
  end

  always_ff @(posedge clk_fast or negedge rst_fast_n) begin
    if (!rst_fast_n) begin
      seen_q <= 1'b0;
      fast_q <= '0;
    end else begin
      seen_q <= seen_d;
      fast_q <= fast_d;
    end
  end

  assign cpu_val  = hold_q;
  assign fast_val = fast_q;

  AST_RDBK_NEXT: assert property (@(posedge clk_cpu) disable iff (!rst_cpu_n)
    accept |=> (hold_q == $past(wr_data)));  // R2
  AST_OVERRUN_KEEPS: assert property (@(posedge clk_cpu) disable iff (!rst_cpu_n)
    overrun |=> $stable(hold_q));  // R4
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_cpu) disable iff (!rst_cpu_n)
    accept |=> busy);  // R5
  AST_FAST_TAKES_HOLD: assert property (@(posedge clk_fast) disable iff (!rst_fast_n)
    load |=> (fast_q == $past(hold_q)));  // R3

endmodule

// File: rtl/trb_rd_lane.sv
module trb_rd_lane #(
  parameter int W = 14
) (
  input  logic         clk_fast,
  input  logic         rst_fast_n,
  input  logic         clk_cpu,
  input  logic         rst_cpu_n,
  input  logic         one_stage,
  input  logic [W-1:0] src,
  output logic [W-1:0] mirror
);

  // Fast side: snapshot holder
  logic         snap_q, snap_d;
  logic         ack_fast;
  logic         pend;
  logic         cap;
  logic [W-1:0] hold_q, hold_d;

  // Processor side: mirror
  logic         snap_cpu;
  logic         seen_q, seen_d;
  logic         load;
  logic [W-1:0] mir_q, mir_d;

  trb_tog_sync u_snap_sync (
    .clk       (clk_cpu),
    .rst_n     (rst_cpu_n),
    .one_stage (one_stage),
    .d         (snap_q),
    .q         (snap_cpu)
  );

  trb_tog_sync u_ack_sync (
    .clk       (clk_fast),
    .rst_n     (rst_fast_n),
    .one_stage (one_stage),
    .d         (seen_q),
    .q         (ack_fast)
  );

  always_comb begin
    pend   = snap_q ^ ack_fast;
    cap    = ~pend;
    snap_d = snap_q ^ cap;
    hold_d = cap ? src : hold_q;
  end

  always_ff @(posedge clk_fast or negedge rst_fast_n) begin
    if (!rst_fast_n) begin
      snap_q <= 1'b0;
      hold_q <= '0;
    end else begin
      snap_q <= snap_d;
      hold_q <= hold_d;
    end
  end

  always_comb begin
    load   = snap_cpu ^ seen_q;
    seen_d = snap_cpu;
    mir_d  = load ? hold_q : mir_q;
  end

  always_ff @(posedge clk_cpu or negedge rst_cpu_n) begin
    if (!rst_cpu_n) begin
      seen_q <= 1'b0;
      mir_q  <= '0;
    end else begin
      seen_q <= seen_d;
      mir_q  <= mir_d;
    end
  end

  assign mirror = mir_q;

  AST_SNAP_FROZEN: assert property (@(posedge clk_fast) disable iff (!rst_fast_n)
    pend |=> $stable(hold_q));  // R7
  AST_MIRROR_FROM_SNAP: assert property (@(posedge clk_cpu) disable iff (!rst_cpu_n)
    load |=> (mir_q == $past(hold_q)));  // R8

endmodule

// File: rtl/trb_bridge.sv
module trb_bridge #(
  parameter int N_REGS = 4,
  parameter int DATA_W = 10,
  parameter int FLAG_W = 4
) (
  input  logic                          clk_cpu,
  input  logic                          clk_fast,
  input  logic                          rst_n,
  input  logic                          sync_mode,
  input  logic                          wr_en,
  input  logic [$clog2(N_REGS+2)-1:0]   wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  output logic                          wr_accept,
  output logic                          wr_overrun,
  output logic [N_REGS-1:0]             wr_busy,
  input  logic [$clog2(N_REGS+2)-1:0]   rd_addr,
  output logic [DATA_W-1:0]             rd_data,
  output logic [N_REGS*DATA_W-1:0]      cfg_fast,
  input  logic [DATA_W-1:0]             tmr_count,
  input  logic [FLAG_W-1:0]             tmr_flags
);

  import trb_pkg::*;

  localparam int ADDR_W = $clog2(N_REGS + 2);
  localparam int STAT_W = DATA_W + FLAG_W;
  localparam logic [ADDR_W-1:0] ADDR_CNT = ADDR_W'(N_REGS);
  localparam logic [ADDR_W-1:0] ADDR_FLG = ADDR_W'(N_REGS + 1);

  logic rst_cpu_n;
  logic rst_fast_n;

  logic [N_REGS-1:0] hit;
  logic [N_REGS-1:0] acc_v;
  logic [N_REGS-1:0] ovr_v;
  logic [DATA_W-1:0] reg_cpu [N_REGS];
  logic [STAT_W-1:0] stat_mirror;
  trb_rsel_e         rsel;

  trb_rst_sync u_rst_cpu (
    .clk     (clk_cpu),
    .arst_n  (rst_n),
    .rst_n_o (rst_cpu_n)
  );

  trb_rst_sync u_rst_fast (
    .clk     (clk_fast),
    .arst_n  (rst_n),
    .rst_n_o (rst_fast_n)
  );

  for (genvar i = 0; i < N_REGS; i++) begin : g_lane
    assign hit[i] = wr_en && (wr_addr == ADDR_W'(i));

    trb_wr_lane #(.DW(DATA_W)) u_wr (
      .clk_cpu    (clk_cpu),
      .rst_cpu_n  (rst_cpu_n),
      .clk_fast   (clk_fast),
      .rst_fast_n (rst_fast_n),
      .one_stage  (sync_mode),
      .wr_hit     (hit[i]),
      .wr_data    (wr_data),
      .accept     (acc_v[i]),
      .overrun    (ovr_v[i]),
      .busy       (wr_busy[i]),
      .cpu_val    (reg_cpu[i]),
      .fast_val   (cfg_fast[i*DATA_W +: DATA_W])
    );
  end

  assign wr_accept  = |acc_v;
  assign wr_overrun = |ovr_v;

  trb_rd_lane #(.W(STAT_W)) u_stat (
    .clk_fast   (clk_fast),
    .rst_fast_n (rst_fast_n),
    .clk_cpu    (clk_cpu),
    .rst_cpu_n  (rst_cpu_n),
    .one_stage  (sync_mode),
    .src        ({tmr_flags, tmr_count}),
    .mirror     (stat_mirror)
  );

  always_comb begin
    if (rd_addr < ADDR_CNT) begin
      rsel = RSEL_REG;
    end else if (rd_addr == ADDR_CNT) begin
      rsel = RSEL_CNT;
    end else if (rd_addr == ADDR_FLG) begin
      rsel = RSEL_FLG;
    end else begin
      rsel = RSEL_NONE;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rsel)
      RSEL_REG: begin
        for (int i = 0; i < N_REGS; i++) begin
          if (rd_addr == ADDR_W'(i)) rd_data = reg_cpu[i];
        end
      end
      RSEL_CNT: rd_data = stat_mirror[DATA_W-1:0];
      RSEL_FLG: rd_data = DATA_W'(stat_mirror[STAT_W-1:DATA_W]);
      default:  rd_data = '0;
    endcase
  end

  AST_WR_EXCLUSIVE: assert property (@(posedge clk_cpu) disable iff (!rst_cpu_n)
    !(wr_accept && wr_overrun));  // R4
  AST_OOR_SILENT: assert property (@(posedge clk_cpu) disable iff (!rst_cpu_n)
    (wr_en && (wr_addr >= ADDR_CNT)) |-> (!wr_accept && !wr_overrun));  // R6

endmodule

// File: tb/trb_bridge_tb.sv
module trb_bridge_tb;

  localparam int NR = 4;
  localparam int DW = 10;
  localparam int FW = 4;
  localparam int AW = 3;

  logic clk_cpu = 1'b0;
  logic osc = 1'b0;
  logic clk_fast;
  logic rst_n = 1'b0;
  logic sync_mode = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic wr_accept, wr_overrun;
  logic [NR-1:0] wr_busy;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic [NR*DW-1:0] cfg_fast;
  logic [DW-1:0] stub_cnt;
  logic [FW-1:0] stub_flags;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk_cpu = ~clk_cpu;   // 50 MHz
  always #3.5 osc = ~osc;          // unrelated fast clock
  assign clk_fast = sync_mode ? clk_cpu : osc;

  // Timer stub: free-running counter and flags derived from it
  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) stub_cnt <= '0;
    else        stub_cnt <= stub_cnt + 1'b1;
  end
  assign stub_flags = stub_cnt[3:0] ^ stub_cnt[9:6];

  trb_bridge u_dut (
    .clk_cpu    (clk_cpu),
    .clk_fast   (clk_fast),
    .rst_n      (rst_n),
    .sync_mode  (sync_mode),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .wr_accept  (wr_accept),
    .wr_overrun (wr_overrun),
    .wr_busy    (wr_busy),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .cfg_fast   (cfg_fast),
    .tmr_count  (stub_cnt),
    .tmr_flags  (stub_flags)
  );

  task automatic chk(input string tag, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int cfg_of(input int a);
    return int'(cfg_fast[a*DW +: DW]);
  endfunction

  function automatic int flag_fn(input int c);
    return (c & 15) ^ ((c >> 6) & 15);
  endfunction

  task automatic do_reset(input bit mode);
    @(negedge clk_cpu);
    rst_n = 1'b0;
    sync_mode = mode;
    wr_en = 1'b0;
    repeat (4) @(negedge clk_cpu);
    chk("R1 cfg_fast in reset", cfg_fast == '0, int'(cfg_fast[DW-1:0]), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk_cpu);
  endtask

  task automatic check_reset_state();
    #1;
    for (int a = 0; a < NR; a++) begin
      rd_addr = AW'(a);
      #1;
      chk("R1 readback zero", rd_data == '0, int'(rd_data), 0);
      chk("R1 fast copy zero", cfg_of(a) == 0, cfg_of(a), 0);
    end
    chk("R1 busy clear", wr_busy == '0, int'(wr_busy), 0);
  endtask

  // Shared-clock write with cycle-exact checks
  task automatic wr_sync(input int a, input int v);
    int old;
    old = cfg_of(a);
    @(negedge clk_cpu);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(v);
    #1;
    chk("R5 accept idle", wr_accept == 1'b1 && wr_overrun == 1'b0, int'(wr_accept), 1);
    @(negedge clk_cpu);                 // after write edge
    wr_en = 1'b0; rd_addr = AW'(a);
    #1;
    chk("R2 readback", int'(rd_data) == v, int'(rd_data), v);
    chk("R3 not early (1)", cfg_of(a) == old, cfg_of(a), old);
    chk("R5 busy edge1", wr_busy[a] == 1'b1, int'(wr_busy[a]), 1);
    @(negedge clk_cpu);
    #1;
    chk("R3 not early (2)", cfg_of(a) == old, cfg_of(a), old);
    chk("R5 busy edge2", wr_busy[a] == 1'b1, int'(wr_busy[a]), 1);
    @(negedge clk_cpu);
    #1;
    chk("R3 exact delivery", cfg_of(a) == v, cfg_of(a), v);
    chk("R5 busy edge3", wr_busy[a] == 1'b1, int'(wr_busy[a]), 1);
    @(negedge clk_cpu);
    #1;
    chk("R5 busy released", wr_busy[a] == 1'b0, int'(wr_busy[a]), 0);
  endtask

  // Unrelated clocks: bounded handshake
  task automatic wr_async(input int a, input int v);
    int n;
    int others [NR];
    for (int b = 0; b < NR; b++) others[b] = cfg_of(b);
    @(negedge clk_cpu);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(v);
    #1;
    chk("R5 accept idle", wr_accept == 1'b1 && wr_overrun == 1'b0, int'(wr_accept), 1);
    @(negedge clk_cpu);
    wr_en = 1'b0; rd_addr = AW'(a);
    #1;
    chk("R2 readback", int'(rd_data) == v, int'(rd_data), v);
    n = 0;
    while (wr_busy[a] && n < 12) begin
      @(negedge clk_cpu);
      #1;
      n++;
    end
    chk("R5 busy bounded", n <= 6, n, 6);
    chk("R3 delivered", cfg_of(a) == v, cfg_of(a), v);
    for (int b = 0; b < NR; b++) begin
      if (b != a) chk("R3 others untouched", cfg_of(b) == others[b], cfg_of(b), others[b]);
    end
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    while (wr_busy != '0 && n < 20) begin
      @(negedge clk_cpu);
      #1;
      n++;
    end
  endtask

  task automatic overrun_case(input int a, input int b, input int v1, input int v2, input int vb);
    @(negedge clk_cpu);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(v1);
    #1;
    chk("R5 first accept", wr_accept == 1'b1, int'(wr_accept), 1);
    @(negedge clk_cpu);
    wr_data = DW'(v2);
    #1;
    chk("R4 overrun raised", wr_overrun == 1'b1, int'(wr_overrun), 1);
    chk("R4 no accept", wr_accept == 1'b0, int'(wr_accept), 0);
    @(negedge clk_cpu);
    wr_addr = AW'(b); wr_data = DW'(vb);
    #1;
    chk("R5 other register free", wr_accept == 1'b1 && wr_overrun == 1'b0, int'(wr_accept), 1);
    rd_addr = AW'(a);
    #1;
    chk("R4 readback keeps first", int'(rd_data) == v1, int'(rd_data), v1);
    @(negedge clk_cpu);
    wr_en = 1'b0;
    wait_idle();
    rd_addr = AW'(a);
    #1;
    chk("R4 readback final", int'(rd_data) == v1, int'(rd_data), v1);
    chk("R4 fast copy keeps first", cfg_of(a) == v1, cfg_of(a), v1);
    chk("R5 other delivered", cfg_of(b) == vb, cfg_of(b), vb);
  endtask

  task automatic decode_case();
    int keep [NR];
    for (int b = 0; b < NR; b++) keep[b] = cfg_of(b);
    for (int x = NR; x < (1 << AW); x++) begin
      @(negedge clk_cpu);
      wr_en = 1'b1; wr_addr = AW'(x); wr_data = 10'h3c5;
      #1;
      chk("R6 out-of-range write silent", wr_accept == 1'b0 && wr_overrun == 1'b0,
          int'({wr_accept, wr_overrun}), 0);
    end
    @(negedge clk_cpu);
    wr_en = 1'b0;
    repeat (8) @(negedge clk_cpu);
    #1;
    for (int b = 0; b < NR; b++) begin
      rd_addr = AW'(b);
      #1;
      chk("R6 registers unchanged", int'(rd_data) == keep[b], int'(rd_data), keep[b]);
      chk("R6 fast copies unchanged", cfg_of(b) == keep[b], cfg_of(b), keep[b]);
    end
    for (int x = NR + 2; x < (1 << AW); x++) begin
      rd_addr = AW'(x);
      #1;
      chk("R6 unused address reads zero", rd_data == '0, int'(rd_data), 0);
    end
    rd_addr = AW'(NR + 1);
    #1;
    chk("R6 flag word upper bits zero", rd_data[DW-1:FW] == '0, int'(rd_data), int'(rd_data[FW-1:0]));
  endtask

  task automatic coherence_case(input int reps);
    int c, f;
    for (int k = 0; k < reps; k++) begin
      @(negedge clk_cpu);
      rd_addr = AW'(NR);
      #1;
      c = int'(rd_data);
      rd_addr = AW'(NR + 1);
      #1;
      f = int'(rd_data);
      chk("R7 flag mirror matches count mirror", f == flag_fn(c), f, flag_fn(c));
    end
  endtask

  task automatic status_sync();
    int prev, cur, last, exp;
    rd_addr = AW'(NR);
    @(negedge clk_cpu);
    #1;
    prev = int'(rd_data);
    last = -1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk_cpu);
      #1;
      cur = int'(rd_data);
      if (cur != prev) begin
        exp = (int'(stub_cnt) - 3) & 10'h3ff;
        chk("R8 sample age three edges", cur == exp, cur, exp);
        if (last >= 0) chk("R8 refresh period four", (k - last) == 4, k - last, 4);
        last = k;
      end
      prev = cur;
    end
    chk("R8 mirror refreshed", last >= 0, last, 0);
  endtask

  task automatic status_async();
    int cur, lag;
    rd_addr = AW'(NR);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk_cpu);
      #1;
      cur = int'(rd_data);
      lag = (int'(stub_cnt) - cur) & 10'h3ff;
      chk("R8 bounded lag", lag >= 1 && lag <= 40, lag, 40);
    end
  endtask

  initial begin
    int vals [6];
    vals[0] = 10'h3ff; vals[1] = 10'h000; vals[2] = 10'h155;
    vals[3] = 10'h2aa; vals[4] = 10'h001; vals[5] = 10'h200;

    // Shared-clock mode
    do_reset(1'b1);
    check_reset_state();
    for (int a = 0; a < NR; a++) begin
      for (int i = 0; i < 6; i++) wr_sync(a, vals[i] ^ (a << 2));
    end
    overrun_case(1, 2, 10'h0f3, 10'h30c, 10'h111);
    decode_case();
    status_sync();
    coherence_case(20);

    // Unrelated clocks
    do_reset(1'b0);
    check_reset_state();
    for (int a = 0; a < NR; a++) begin
      for (int i = 0; i < 6; i++) wr_async(a, vals[i] ^ (a << 3));
    end
    overrun_case(3, 0, 10'h2c1, 10'h13e, 10'h0aa);
    decode_case();
    status_async();
    coherence_case(20);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_cpu);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule